// File: doc/BRIEF.md
# Cascaded Wake-Up Setup Sequencer

This block brings a system back from deep sleep by switching on a chain of analog cells, an oscillator first and then a regulator, one after the other. Each cell has a setup counter. The counter is loaded with that cell's stabilization time and counts down on slow-clock ticks. When a counter runs out, the next cell is switched on and its counter starts. When the last counter runs out, the processor reset is released. The chain has `NSTAGE` stages, from one to six, and the default build has two.

While the system runs, the processor requests idle. The sequencer acknowledges the request. If no wake-up event interrupts the handshake, it drops every cell enable and holds the processor in reset. A wake-up event that arrives during deep sleep starts the cascade. When the cascade ends, every cell is enabled, reset is released and a single-cycle done pulse is raised. The sequencer then returns to its running state. Reload values come from an external register file, one field of `CW` bits per stage. Stage 0 takes the lowest field.

Top module: `wake_seq`

## Requirements
- R1: After reset the block is running: all cell enables are 1, `proc_rst`, `idle_ack` and `done` are 0.
- R2: `idle_req` high while running raises `idle_ack` one cycle later, with all cell enables still 1 and `proc_rst` still 0.
- R3: If `idle_req` is still high and `wake_evt` is low in the cycle after the acknowledge, the block enters sleep: every cell enable goes to 0 and `proc_rst` to 1, with `idle_ack` still 1.
- R4: A `wake_evt`, or a withdrawn `idle_req`, in the acknowledge cycle aborts the idle. The block returns to running with `idle_ack` 0, and no cell enable ever drops.
- R5: `wake_evt` during sleep enables cell 0 on the next cycle, loads the stage-0 counter from `reload[CW-1:0]`, drops `idle_ack` and keeps `proc_rst` at 1.
- R6: Stage k lasts exactly `reload[k*CW +: CW] + 1` ticks. On the clock edge of its final tick, the enable of cell k+1 goes high and the counter of stage k+1 loads. Enables only ever form a thermometer code from bit 0 upward.
- R7: A setup counter changes only in cycles where `tick` is 1. With `tick` low, the count and the enables hold.
- R8: A stage with reload value 0 underflows on the first tick after it starts.
- R9: On the final tick of the last stage, `proc_rst` falls, `done` is 1 for exactly one cycle with all enables 1, and the block is running again on the following cycle.
- R10: `idle_req` and `wake_evt` have no effect while the cascade is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Slow-clock tick enable for the setup counters |
| idle_req | input | 1 | Idle request from the processor |
| wake_evt | input | 1 | Wake-up event |
| reload | input | NSTAGE*CW | Stabilization time per stage, stage k in bits k*CW+CW-1:k*CW |
| cell_en | output | NSTAGE | Analog cell enables, bit k for stage k |
| proc_rst | output | 1 | Processor reset, active high |
| idle_ack | output | 1 | Idle acknowledge |
| done | output | 1 | One-cycle pulse at the end of the wake-up cascade |

## Verification
The bench checks the cycle on which each enable rises, for several reload pairs and for a sparse tick pattern. A counter that decrements without a tick would end the stage early, and one that underflows a step late would end it late. Zero reload values check that a stage lasts exactly one tick. A design that skipped the load, or waited for a second tick, would miss the expected cycle. An idle aborted by a wake-up, and an idle withdrawn by the processor, must return to running without any enable dropping. Stray `idle_req` and `wake_evt` pulses during the cascade must not change any output. A design that reacted to them would show an unexpected output change, and the scoreboard counts that as a failure.

// File: rtl/wake_seq.sv
module wake_seq #(
  parameter int NSTAGE = 2,
  parameter int CW     = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick,
  input  logic                 idle_req,
  input  logic                 wake_evt,
  input  logic [NSTAGE*CW-1:0] reload,
  output logic [NSTAGE-1:0]    cell_en,
  output logic                 proc_rst,
  output logic                 idle_ack,
  output logic                 done
);
  localparam int SW = (NSTAGE > 1) ? $clog2(NSTAGE) : 1;
  localparam logic [SW-1:0] LAST = SW'(NSTAGE - 1);

  typedef enum logic [2:0] {S_RUN, S_IDLE, S_SLEEP, S_WAKE, S_REL} st_t;

  st_t           state;
  logic [SW-1:0] stg, stg_nx;
  logic [CW-1:0] cnt;
  logic          last;

  assign last   = (stg == LAST);
  assign stg_nx = last ? stg : stg + 1'b1;

  assign proc_rst = (state == S_SLEEP) || (state == S_WAKE);
  assign idle_ack = (state == S_IDLE)  || (state == S_SLEEP);
  assign done     = (state == S_REL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_RUN;
      stg     <= '0;
      cnt     <= '0;
      cell_en <= '1;
    end else begin
      case (state)
        S_RUN:   if (idle_req) state <= S_IDLE;
        S_IDLE: begin
          if (wake_evt || !idle_req) state <= S_RUN;
          else begin
            state   <= S_SLEEP;
            cell_en <= '0;
          end
        end
        S_SLEEP: if (wake_evt) begin
          state      <= S_WAKE;
          stg        <= '0;
          cnt        <= reload[CW-1:0];
          cell_en[0] <= 1'b1;
        end
        S_WAKE: if (tick) begin
          if (cnt == '0) begin
            if (last) state <= S_REL;
            else begin
              stg             <= stg_nx;
              cnt             <= reload[int'(stg_nx)*CW +: CW];
              cell_en[stg_nx] <= 1'b1;
            end
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        S_REL:   state <= S_RUN;
        default: state <= S_RUN;
      endcase
    end
  end

  // R2
  ack_cells_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_ack && !proc_rst) |-> (&cell_en));

  // R3
  sleep_cells_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_ack && proc_rst) |-> (cell_en == '0));

  // R6
  thermo_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((cell_en & (cell_en + 1'b1)) == '0));

  // R7
  hold_no_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_WAKE && !tick) |=> ($stable(cnt) && $stable(cell_en)));

  // R9
  release_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(proc_rst) |-> (done && (&cell_en)));

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

// File: tb/wake_seq_tb.sv
module wake_seq_tb_top;
  localparam int NS = 2;
  localparam int CW = 8;

  typedef struct {
    int            cyc;
    logic [NS-1:0] en;
    logic          rst;
    logic          ack;
    logic          dn;
    string         req;
  } exp_t;

  logic clk = 1'b0, rst_n = 1'b0;
  logic idle_req = 1'b0, wake_evt = 1'b0;
  logic [NS*CW-1:0] reload = '0;
  logic [NS-1:0] cell_en;
  logic proc_rst, idle_ack, done, tick;

  int cyc = 0, period = 1, checks = 0, failures = 0;
  bit mon_on = 1'b0;
  exp_t sb[$];

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  assign tick = (cyc % period) == 0;

  wake_seq #(.NSTAGE(NS), .CW(CW)) dut_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .idle_req(idle_req),
    .wake_evt(wake_evt), .reload(reload), .cell_en(cell_en),
    .proc_rst(proc_rst), .idle_ack(idle_ack), .done(done)
  );

  function automatic int stage_end(int s, int r);
    int e = s, n = 0;
    while (n < r + 1) begin
      e++;
      if (((e - 1) % period) == 0) n++;
    end
    return e;
  endfunction

  function automatic void push(int c, logic [NS-1:0] en, logic r, logic a, logic d, string q);
    exp_t x;
    x.cyc = c; x.en = en; x.rst = r; x.ack = a; x.dn = d; x.req = q;
    sb.push_back(x);
  endfunction

  initial begin
    logic [NS+2:0] prev, cur;
    exp_t x;
    prev = '0;
    forever begin
      @(negedge clk);
      cur = {cell_en, proc_rst, idle_ack, done};
      if (mon_on && cur !== prev) begin
        checks++;
        if (sb.size() == 0) begin
          failures++;
          $display("FAIL R10 unexpected change at cyc %0d: actual %b expected no change", cyc, cur);
        end else begin
          x = sb.pop_front();
          if (cur !== {x.en, x.rst, x.ack, x.dn} || cyc != x.cyc) begin
            failures++;
            $display("FAIL %s actual %b@%0d expected %b@%0d", x.req, cur, cyc,
                     {x.en, x.rst, x.ack, x.dn}, x.cyc);
          end
        end
      end
      prev = cur;
    end
  end

  task automatic drain();
    int guard = 0;
    while (sb.size() != 0 && guard < 500) begin
      @(negedge clk);
      guard++;
    end
    repeat (4) @(negedge clk);
  endtask

  // R2 R3: enter sleep
  task automatic go_sleep();
    @(negedge clk);
    push(cyc + 1, '1, 1'b0, 1'b1, 1'b0, "R2");
    push(cyc + 2, '0, 1'b1, 1'b1, 1'b0, "R3");
    idle_req = 1'b1;
    @(negedge clk);
    @(negedge clk);
    idle_req = 1'b0;
    drain();
  endtask

  // R5 R6 R8 R9 R10: run the cascade
  task automatic go_wake(int r0, int r1, bit noise);
    int s, e;
    reload = {CW'(r1), CW'(r0)};
    @(negedge clk);
    s = cyc + 1;
    push(s, 2'b01, 1'b1, 1'b0, 1'b0, "R5");
    e = stage_end(s, r0);
    push(e, 2'b11, 1'b1, 1'b0, 1'b0, (r0 == 0) ? "R8" : "R6");
    e = stage_end(e, r1);
    push(e, 2'b11, 1'b0, 1'b0, 1'b1, "R9");
    push(e + 1, 2'b11, 1'b0, 1'b0, 1'b0, "R9");
    wake_evt = 1'b1;
    @(negedge clk);
    wake_evt = 1'b0;
    if (noise) begin
      @(negedge clk);
      idle_req = 1'b1; wake_evt = 1'b1;
      @(negedge clk);
      idle_req = 1'b0; wake_evt = 1'b0;
    end
    drain();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    checks++;
    if ({cell_en, proc_rst, idle_ack, done} !== {2'b11, 3'b000}) begin
      failures++;
      $display("FAIL R1 actual %b expected %b", {cell_en, proc_rst, idle_ack, done}, {2'b11, 3'b000});
    end
    mon_on = 1'b1;

    // R10: wake_evt while running is ignored
    wake_evt = 1'b1; @(negedge clk); wake_evt = 1'b0;
    repeat (3) @(negedge clk);

    period = 1;
    go_sleep(); go_wake(3, 5, 1'b1);

    // R4: wake during the acknowledge cycle aborts
    @(negedge clk);
    push(cyc + 1, '1, 1'b0, 1'b1, 1'b0, "R2");
    push(cyc + 2, '1, 1'b0, 1'b0, 1'b0, "R4");
    idle_req = 1'b1;
    @(negedge clk);
    wake_evt = 1'b1;
    @(negedge clk);
    idle_req = 1'b0; wake_evt = 1'b0;
    drain();

    // R4: request withdrawn during the acknowledge cycle
    @(negedge clk);
    push(cyc + 1, '1, 1'b0, 1'b1, 1'b0, "R2");
    push(cyc + 2, '1, 1'b0, 1'b0, 1'b0, "R4");
    idle_req = 1'b1;
    @(negedge clk);
    idle_req = 1'b0;
    drain();

    // R7: sparse ticks
    period = 3;
    go_sleep(); go_wake(2, 1, 1'b0);
    period = 5;
    go_sleep(); go_wake(4, 0, 1'b1);

    // R8: zero reloads
    period = 1;
    go_sleep(); go_wake(0, 0, 1'b0);
    go_sleep(); go_wake(1, 7, 1'b0);

    checks++;
    if (sb.size() != 0) begin
      failures++;
      $display("FAIL R6 events missing: actual %0d pending expected 0", sb.size());
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #40000;
    failures++;
    $display("FAIL watchdog expired: actual timeout expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule